// File: doc/BRIEF.md
# Extended IO Interrupt Router

The router takes 256 level-sensitive interrupt lines and steers each one to one of four cores. Each core has four parent interrupt outputs. Lines are handled in groups of 32, and each group shares one parent-map byte that picks which of the four parent outputs its lines drive. Each line also has its own core-map byte that picks its destination core. A configuration byte selects how the map bytes are read. In mask mode the lowest set bit gives the index. In encoded mode the byte value is the index. In both modes an out-of-range result falls back to index 0.

A rising line records a raw pending bit. If the line is enabled, it also sets the line's bit in the status register of its mapped core. A parent output stays high while any status bit routed to it is set. Software clears status bits by writing 1s, and each core sees only its own status. Changing an enable bit or a core-map byte while a line is high re-steers that line at once, with no need to wait for a new edge.

Software reaches all registers through a single-cycle port. The port takes a valid, write, address, size and data, plus the identity of the requesting core. It returns read data and an error flag in the same cycle as the request.

Top module: `eio_router`

## Requirements
- R1: After reset every register reads zero, and every line maps to core 0 and parent 0. All parent outputs are low, and the configuration byte is 0 (mask mode, controller disabled).
- R2: Lines 32g..32g+31 share the parent-map byte at offset g (0x00-0x07). With configuration bit 1 clear, the parent is the index of the lowest set bit, and an all-zero byte or an index of 4 or more gives parent 0. With bit 1 set, the byte value is the parent, and values of 4 or more give parent 0. Output parent_irq[core*4+parent] belongs to that core and parent.
- R3: Line n has its core-map byte at offset 0x80+n. This byte decodes the same way as in R2, with configuration bit 2 choosing encoded mode and core 0 as the fallback.
- R4: A rising line always sets its pending state. If its enable bit is set (offset 0x20+n/8, bit n%8), it also sets status bit n of its mapped core, and the parent output rises on the clock edge that samples the rise. A line that rises while disabled produces no output. A falling line withdraws its status bit.
- R5: A core's parent output is high exactly while at least one status bit of that core, belonging to a group that decodes to that parent, is set.
- R6: Status bits sit at offsets 0x60-0x7F (bit n at 0x60+n/8, bit n%8). Reads and writes there use the status of the core given on req_core. Writing 1 clears the bit, writing 0 keeps it, and the other cores' status is unaffected.
- R7: Setting an enable bit while the line is high routes the line as if it had just risen. Clearing an enable bit while the line is high withdraws the line from its core.
- R8: A core-map write that changes the decoded core of a high, enabled line moves its status bit from the old core to the new core in the same cycle. A line's status bit is never held by more than one core.
- R9: req_size 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes, placed in little-endian byte lanes. The address must be aligned to the size. The valid ranges are 0x00-0x07, 0x10-0x7F, 0x80-0x17F, the 8-byte word at 0x180 and the 8-byte word at 0x188. A misaligned access or one outside these ranges raises rsp_err, reads as zero and changes nothing.
- R10: The configuration byte at 0x180 holds bit 0 enable, bit 1 encoded parent map and bit 2 encoded core map. It stores the written value ANDed with FEATURE_MASK, which reads back at 0x188. A nonzero write while bit 0 is set is refused with rsp_err, and any write to 0x188 is refused.
- R11: Node-type bytes (0x10-0x1F) and bounce bits (0x40-0x5F) are stored and read back but have no effect on routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 256 | Level-sensitive interrupt lines, synchronous to clk |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_core | input | 2 | Identity of the requesting core, used to select the status view |
| req_addr | input | 9 | Byte offset of the access |
| req_size | input | 2 | Access size: 0, 1, 2 or 3 for 1, 2, 4 or 8 bytes |
| req_wdata | input | 64 | Write data, with the lowest byte going to the lowest address |
| rsp_rdata | output | 64 | Read data in the same cycle, zero on error |
| rsp_err | output | 1 | Access refused (bad address, misaligned, or protected register) |
| parent_irq | output | 16 | Parent outputs, with bit core*4+parent |

## Verification
The hardest state to reach is a line that is held high and enabled while its routing is changed underneath it. A core-map rewrite or an enable change must then move or withdraw its status bit without a new edge on the line. The directed stimulus raises a line and holds it. It then clears that line's status from a core that does not own it, rewrites the core-map byte, and later drops the enable. After each step it reads the status register through every core's view and checks the parent outputs. Encoded mode, including the out-of-range fallback values, is reached by writing the configuration byte while the controller is disabled.

// File: rtl/eio_pkg.sv
`timescale 1ns/1ps
package eio_pkg;
    localparam int NUM_LINES   = 256;
    localparam int NUM_CORES   = 4;
    localparam int NUM_PARENTS = 4;
    localparam int GROUP_SIZE  = 32;
    localparam int NUM_GROUPS  = NUM_LINES / GROUP_SIZE;
    localparam int CORE_W      = $clog2(NUM_CORES);
    localparam int PAR_W       = $clog2(NUM_PARENTS);
    localparam int ADDR_W      = 9;
    localparam int DATA_W      = 64;
    localparam int LANES       = DATA_W / 8;
    localparam int NODE_BYTES  = 16;
    localparam int OUT_W       = NUM_CORES * NUM_PARENTS;

    // word (8-byte) indices of each register region
    localparam logic [5:0] W_PMAP = 6'd0;
    localparam logic [5:0] W_NODE = 6'd2;
    localparam logic [5:0] W_EN   = 6'd4;
    localparam logic [5:0] W_BNC  = 6'd8;
    localparam logic [5:0] W_STAT = 6'd12;
    localparam logic [5:0] W_CMAP = 6'd16;
    localparam logic [5:0] W_CFG  = 6'd48;
    localparam logic [5:0] W_FEAT = 6'd49;
    localparam logic [5:0] NODE_WORDS = 6'(NODE_BYTES / LANES);
    localparam logic [5:0] LINE_WORDS = 6'(NUM_LINES / DATA_W);
    localparam logic [5:0] CMAP_WORDS = 6'(NUM_LINES / LANES);

    localparam int CFG_EN   = 0;
    localparam int CFG_PENC = 1;
    localparam int CFG_CENC = 2;

    typedef enum logic [3:0] {
        REG_NONE, REG_PMAP, REG_NODE, REG_EN, REG_BNC,
        REG_STAT, REG_CMAP, REG_CFG, REG_FEAT
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_GROUPS*8-1:0]          pmap;
        logic [NODE_BYTES*8-1:0]          node;
        logic [NUM_LINES-1:0]             en;
        logic [NUM_LINES-1:0]             bnc;
        logic [NUM_CORES*NUM_LINES-1:0]   stat;
        logic [NUM_LINES*8-1:0]           cmap;
        logic [NUM_LINES-1:0]             pend;
        logic [7:0]                       cfg;
    } router_state_t;

    // Decode a map byte: encoded value, or lowest set bit; out of range -> 0
    function automatic int unsigned pick_index(logic [7:0] v, logic encoded,
                                               int unsigned limit);
        int unsigned r;
        r = 0;
        if (encoded) begin
            if (32'(v) < limit) r = 32'(v);
        end else begin
            for (int b = 7; b >= 0; b--) begin
                if (v[b]) r = b;
            end
            if (r >= limit) r = 0;
        end
        return r;
    endfunction
endpackage

// File: rtl/eio_access_decode.sv
`timescale 1ns/1ps
module eio_access_decode
    import eio_pkg::*;
(
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic [DATA_W-1:0]   req_wdata,
    output reg_sel_e            sel,
    output logic [5:0]          word_rel,
    output logic [2:0]          byte_off,
    output logic [LANES-1:0]    byte_en,
    output logic [DATA_W-1:0]   wlane,
    output logic [DATA_W-1:0]   rd_mask,
    output logic                bad
);
    logic [5:0]       word;
    logic [2:0]       align_mask;
    logic [LANES-1:0] be_base;

    assign word     = req_addr[ADDR_W-1:3];
    assign byte_off = req_addr[2:0];

    always_comb begin
        unique case (req_size)
            2'd0: begin be_base = 8'h01; rd_mask = 64'h0000_0000_0000_00FF; align_mask = 3'd0; end
            2'd1: begin be_base = 8'h03; rd_mask = 64'h0000_0000_0000_FFFF; align_mask = 3'd1; end
            2'd2: begin be_base = 8'h0F; rd_mask = 64'h0000_0000_FFFF_FFFF; align_mask = 3'd3; end
            default: begin be_base = 8'hFF; rd_mask = '1; align_mask = 3'd7; end
        endcase
    end

    assign byte_en = be_base << byte_off;
    assign wlane   = req_wdata << {byte_off, 3'b000};

    always_comb begin
        sel      = REG_NONE;
        word_rel = 6'd0;
        if (word == W_PMAP) begin
            sel = REG_PMAP;
        end else if (word >= W_NODE && word < W_NODE + NODE_WORDS) begin
            sel = REG_NODE; word_rel = word - W_NODE;
        end else if (word >= W_EN && word < W_EN + LINE_WORDS) begin
            sel = REG_EN; word_rel = word - W_EN;
        end else if (word >= W_BNC && word < W_BNC + LINE_WORDS) begin
            sel = REG_BNC; word_rel = word - W_BNC;
        end else if (word >= W_STAT && word < W_STAT + LINE_WORDS) begin
            sel = REG_STAT; word_rel = word - W_STAT;
        end else if (word >= W_CMAP && word < W_CMAP + CMAP_WORDS) begin
            sel = REG_CMAP; word_rel = word - W_CMAP;
        end else if (word == W_CFG) begin
            sel = REG_CFG;
        end else if (word == W_FEAT) begin
            sel = REG_FEAT;
        end
    end

    assign bad = ((byte_off & align_mask) != 3'd0) || (sel == REG_NONE)
              || (req_write && sel == REG_FEAT);
endmodule

// File: rtl/eio_parent_merge.sv
`timescale 1ns/1ps
module eio_parent_merge
    import eio_pkg::*;
(
    input  logic [NUM_CORES*NUM_LINES-1:0] stat,
    input  logic [NUM_GROUPS*8-1:0]        pmap,
    input  logic                           par_enc,
    output logic [OUT_W-1:0]               parent_irq
);
    logic [NUM_CORES*NUM_GROUPS-1:0] grp_any;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            assign grp_any[c*NUM_GROUPS+g] = |stat[c*NUM_LINES + g*GROUP_SIZE +: GROUP_SIZE];
        end
    end

    always_comb begin
        parent_irq = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            int unsigned p;
            p = pick_index(pmap[g*8 +: 8], par_enc, NUM_PARENTS);
            for (int c = 0; c < NUM_CORES; c++) begin
                if (grp_any[c*NUM_GROUPS+g]) parent_irq[c*NUM_PARENTS + int'(p)] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/eio_router.sv
`timescale 1ns/1ps
module eio_router
    import eio_pkg::*;
#(
    parameter logic [7:0] FEATURE_MASK = 8'h07
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   irq_in,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [CORE_W-1:0]      req_core,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [1:0]             req_size,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   rsp_err,
    output logic [OUT_W-1:0]       parent_irq
);
    router_state_t st_d, st_q;

    reg_sel_e              sel;
    logic [5:0]            word_rel;
    logic [2:0]            byte_off;
    logic [LANES-1:0]      byte_en;
    logic [DATA_W-1:0]     wlane;
    logic [DATA_W-1:0]     rd_mask;
    logic                  bad;
    logic                  cfg_reject;
    logic                  wr_ok;
    logic [DATA_W-1:0]     word_val;
    logic [NUM_CORES*NUM_LINES-1:0] stat_flat;
    logic [7:0]            cfg_cur;

    assign stat_flat = st_q.stat;
    assign cfg_cur   = st_q.cfg;

    eio_access_decode u_dec (
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .sel       (sel),
        .word_rel  (word_rel),
        .byte_off  (byte_off),
        .byte_en   (byte_en),
        .wlane     (wlane),
        .rd_mask   (rd_mask),
        .bad       (bad)
    );

    eio_parent_merge u_merge (
        .stat       (stat_flat),
        .pmap       (st_q.pmap),
        .par_enc    (cfg_cur[CFG_PENC]),
        .parent_irq (parent_irq)
    );

    // configuration is locked while enabled, except for a write of zero
    assign cfg_reject = req_write && (sel == REG_CFG) && byte_en[0]
                     && cfg_cur[CFG_EN] && (wlane[7:0] != 8'd0);
    assign rsp_err    = req_valid && (bad || cfg_reject);
    assign wr_ok      = req_valid && req_write && !bad && !cfg_reject;

    // read mux
    always_comb begin
        int wbase;
        wbase    = int'(word_rel) * DATA_W;
        word_val = '0;
        unique case (sel)
            REG_PMAP: word_val = st_q.pmap;
            REG_NODE: word_val = st_q.node[wbase +: DATA_W];
            REG_EN:   word_val = st_q.en[wbase +: DATA_W];
            REG_BNC:  word_val = st_q.bnc[wbase +: DATA_W];
            REG_STAT: word_val = st_q.stat[int'(req_core)*NUM_LINES + wbase +: DATA_W];
            REG_CMAP: word_val = st_q.cmap[wbase +: DATA_W];
            REG_CFG:  word_val = {56'd0, st_q.cfg};
            REG_FEAT: word_val = {56'd0, FEATURE_MASK};
            default:  word_val = '0;
        endcase
    end

    assign rsp_rdata = (req_valid && !rsp_err) ? ((word_val >> {byte_off, 3'b000}) & rd_mask) : '0;

    // next state
    always_comb begin
        int wbase;
        st_d      = st_q;
        st_d.pend = irq_in;
        wbase     = int'(word_rel) * DATA_W;

        if (wr_ok) begin
            for (int b = 0; b < LANES; b++) begin
                if (byte_en[b]) begin
                    unique case (sel)
                        REG_PMAP: st_d.pmap[b*8 +: 8] = wlane[b*8 +: 8];
                        REG_NODE: st_d.node[wbase + b*8 +: 8] = wlane[b*8 +: 8];
                        REG_EN:   st_d.en[wbase + b*8 +: 8] = wlane[b*8 +: 8];
                        REG_BNC:  st_d.bnc[wbase + b*8 +: 8] = wlane[b*8 +: 8];
                        REG_STAT: st_d.stat[int'(req_core)*NUM_LINES + wbase + b*8 +: 8] =
                                      st_q.stat[int'(req_core)*NUM_LINES + wbase + b*8 +: 8]
                                      & ~wlane[b*8 +: 8];
                        REG_CMAP: st_d.cmap[wbase + b*8 +: 8] = wlane[b*8 +: 8];
                        REG_CFG:  if (b == 0) st_d.cfg = wlane[7:0] & FEATURE_MASK;
                        default:  ;
                    endcase
                end
            end
        end

        // per-line steering: raise, withdraw, enable edges and remaps
        for (int i = 0; i < NUM_LINES; i++) begin
            logic [CORE_W-1:0] old_core;
            logic [CORE_W-1:0] new_core;
            old_core = CORE_W'(pick_index(st_q.cmap[i*8 +: 8], cfg_cur[CFG_CENC], NUM_CORES));
            new_core = CORE_W'(pick_index(st_d.cmap[i*8 +: 8], cfg_cur[CFG_CENC], NUM_CORES));
            if (!irq_in[i] || !st_d.en[i]) begin
                for (int c = 0; c < NUM_CORES; c++) st_d.stat[c*NUM_LINES + i] = 1'b0;
            end else if (!st_q.pend[i] || !st_q.en[i] || (old_core != new_core)) begin
                for (int c = 0; c < NUM_CORES; c++) st_d.stat[c*NUM_LINES + i] = 1'b0;
                st_d.stat[int'(new_core)*NUM_LINES + i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/eio_router_chk.sv
`timescale 1ns/1ps
module eio_router_chk
    import eio_pkg::*;
(
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_LINES-1:0]           irq_in,
    input logic                           req_valid,
    input logic                           req_write,
    input logic [ADDR_W-1:0]              req_addr,
    input logic [DATA_W-1:0]              req_wdata,
    input logic [DATA_W-1:0]              rsp_rdata,
    input logic                           rsp_err,
    input logic [OUT_W-1:0]               parent_irq,
    input logic [NUM_CORES*NUM_LINES-1:0] stat,
    input logic [7:0]                     cfg
);
    localparam logic [ADDR_W-1:0] CFG_ADDR = {W_CFG, 3'b000};
    logic [NUM_LINES-1:0] stat_any;

    always_comb begin
        stat_any = '0;
        for (int c = 0; c < NUM_CORES; c++) stat_any |= stat[c*NUM_LINES +: NUM_LINES];
    end

    // R4: a status bit exists only for a line that was high at the last edge
    a_r4_status_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_any & ~$past(irq_in)) == '0);

    // R5: no parent output without a status bit behind it
    a_r5_output_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        (|parent_irq) |-> (|stat_any));

    // R9: refused accesses read as zero
    a_r9_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_err) |-> (rsp_rdata == '0));

    // R10: a nonzero write while enabled leaves the configuration unchanged
    a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == CFG_ADDR && req_wdata[7:0] != 8'd0 && cfg[CFG_EN])
        |=> $stable(cfg));

    // R8: a line is held by at most one core
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [NUM_CORES-1:0] col;
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
            assign col[c] = stat[c*NUM_LINES + i];
        end
        a_r8_single_core: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(col));
    end
endmodule

bind eio_router eio_router_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .parent_irq (parent_irq),
    .stat       (stat_flat),
    .cfg        (cfg_cur)
);

// File: tb/eio_router_tb.sv
`timescale 1ns/1ps
module eio_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [255:0] irq_in = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_core = '0;
    logic [8:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] rsp_rdata;
    logic        rsp_err;
    logic [15:0] parent_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    eio_router u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .req_valid(req_valid), .req_write(req_write), .req_core(req_core),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .parent_irq(parent_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [1:0] sz, input logic [63:0] d,
                      input logic [1:0] core, output logic err);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz;
        req_wdata = d; req_core = core;
        #1 err = rsp_err;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [1:0] sz, input logic [1:0] core,
                      output logic [63:0] data, output logic err);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz; req_core = core;
        #1 begin data = rsp_rdata; err = rsp_err; end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic line(input int idx, input logic v);
        @(negedge clk);
        irq_in[idx] = v;
        @(negedge clk);
    endtask

    task automatic expect_rd(input string req, input logic [8:0] a, input logic [1:0] sz,
                             input logic [1:0] core, input logic [63:0] exp, input logic exp_err);
        logic [63:0] d; logic e;
        rd(a, sz, core, d, e);
        check(req, $sformatf("read %h err", a), {63'd0, e}, {63'd0, exp_err});
        check(req, $sformatf("read %h data", a), d, exp);
    endtask

    task automatic expect_wr(input string req, input logic [8:0] a, input logic [1:0] sz,
                             input logic [63:0] d, input logic [1:0] core, input logic exp_err);
        logic e;
        wr(a, sz, d, core, e);
        check(req, $sformatf("write %h err", a), {63'd0, e}, {63'd0, exp_err});
    endtask

    task automatic t_reset;
        check("R1", "parent after reset", {48'd0, parent_irq}, 64'd0);
        expect_rd("R1", 9'h180, 2'd0, 2'd0, 64'd0, 1'b0);
        expect_rd("R1", 9'h080, 2'd3, 2'd0, 64'd0, 1'b0);
    endtask

    task automatic t_mask_route;
        expect_wr("R3", 9'h085, 2'd0, 64'h04, 2'd0, 1'b0);   // line5 -> core2
        expect_wr("R2", 9'h000, 2'd0, 64'h02, 2'd0, 1'b0);   // group0 -> parent1
        expect_wr("R4", 9'h020, 2'd0, 64'h20, 2'd0, 1'b0);   // enable line5
        line(5, 1'b1);
        check("R4", "line5 routed to core2 parent1", {48'd0, parent_irq}, 64'h0200);
        expect_wr("R3", 9'h086, 2'd0, 64'h10, 2'd0, 1'b0);   // bit4 -> fallback core0
        expect_wr("R4", 9'h020, 2'd0, 64'h60, 2'd0, 1'b0);
        line(6, 1'b1);
        check("R3", "mask fallback core0", {48'd0, parent_irq}, 64'h0202);
        expect_wr("R2", 9'h001, 2'd0, 64'h10, 2'd0, 1'b0);   // group1 bit4 -> parent0
        expect_wr("R4", 9'h025, 2'd0, 64'h01, 2'd0, 1'b0);   // enable line40
        line(40, 1'b1);
        check("R2", "mask fallback parent0", {48'd0, parent_irq}, 64'h0203);
    endtask

    task automatic t_enable_edge;
        expect_wr("R3", 9'h087, 2'd0, 64'h08, 2'd0, 1'b0);   // line7 -> core3
        line(7, 1'b1);
        check("R4", "disabled line has no output", {48'd0, parent_irq}, 64'h0203);
        expect_rd("R4", 9'h060, 2'd0, 2'd3, 64'd0, 1'b0);
        expect_wr("R7", 9'h020, 2'd0, 64'hE0, 2'd0, 1'b0);
        check("R7", "enable while high routes", {48'd0, parent_irq}, 64'h2203);
    endtask

    task automatic t_w1c;
        expect_rd("R6", 9'h060, 2'd0, 2'd2, 64'h20, 1'b0);
        expect_rd("R6", 9'h060, 2'd0, 2'd0, 64'h40, 1'b0);
        expect_wr("R6", 9'h060, 2'd0, 64'h20, 2'd0, 1'b0);   // core0 view: bit5 not set there
        expect_rd("R6", 9'h060, 2'd0, 2'd0, 64'h40, 1'b0);
        expect_rd("R6", 9'h060, 2'd0, 2'd2, 64'h20, 1'b0);
        check("R6", "other core clear has no effect", {48'd0, parent_irq}, 64'h2203);
        expect_wr("R6", 9'h060, 2'd0, 64'h00, 2'd0, 1'b0);   // zeros keep
        expect_rd("R6", 9'h060, 2'd0, 2'd0, 64'h40, 1'b0);
        expect_wr("R6", 9'h060, 2'd0, 64'h20, 2'd2, 1'b0);
        expect_rd("R6", 9'h060, 2'd0, 2'd2, 64'h00, 1'b0);
        check("R6", "clear drops parent", {48'd0, parent_irq}, 64'h2003);
    endtask

    task automatic t_remap;
        expect_wr("R8", 9'h0A8, 2'd0, 64'h02, 2'd0, 1'b0);   // line40 -> core1
        check("R8", "pending line moved", {48'd0, parent_irq}, 64'h2012);
        expect_rd("R8", 9'h065, 2'd0, 2'd1, 64'h01, 1'b0);
        expect_rd("R8", 9'h065, 2'd0, 2'd0, 64'h00, 1'b0);
    endtask

    task automatic t_withdraw;
        expect_wr("R7", 9'h025, 2'd0, 64'h00, 2'd0, 1'b0);
        check("R7", "disable withdraws", {48'd0, parent_irq}, 64'h2002);
        line(7, 1'b0);
        check("R4", "fall withdraws", {48'd0, parent_irq}, 64'h0002);
        line(6, 1'b0);
        line(5, 1'b0);
        line(40, 1'b0);
        check("R5", "all withdrawn", {48'd0, parent_irq}, 64'h0000);
    endtask

    task automatic t_encoded;
        expect_wr("R10", 9'h180, 2'd0, 64'h06, 2'd0, 1'b0);
        expect_rd("R10", 9'h180, 2'd0, 2'd0, 64'h06, 1'b0);
        expect_wr("R2", 9'h002, 2'd0, 64'h03, 2'd0, 1'b0);   // group2 -> parent3
        expect_wr("R3", 9'h0C6, 2'd0, 64'h02, 2'd0, 1'b0);   // line70 -> core2
        expect_wr("R3", 9'h0C7, 2'd0, 64'h09, 2'd0, 1'b0);   // line71 -> fallback core0
        expect_wr("R4", 9'h028, 2'd0, 64'hC0, 2'd0, 1'b0);
        @(negedge clk);
        irq_in[70] = 1'b1; irq_in[71] = 1'b1;
        @(negedge clk);
        check("R2", "encoded routing", {48'd0, parent_irq}, 64'h0808);
        @(negedge clk);
        irq_in[70] = 1'b0; irq_in[71] = 1'b0;
        @(negedge clk);
        check("R5", "encoded lines withdrawn", {48'd0, parent_irq}, 64'h0000);
    endtask

    task automatic t_config;
        expect_wr("R10", 9'h180, 2'd0, 64'hFF, 2'd0, 1'b0);
        expect_rd("R10", 9'h180, 2'd0, 2'd0, 64'h07, 1'b0);
        expect_wr("R10", 9'h180, 2'd0, 64'h02, 2'd0, 1'b1);
        expect_rd("R10", 9'h180, 2'd0, 2'd0, 64'h07, 1'b0);
        expect_rd("R10", 9'h188, 2'd0, 2'd0, 64'h07, 1'b0);
        expect_wr("R10", 9'h188, 2'd0, 64'h00, 2'd0, 1'b1);
        expect_wr("R10", 9'h180, 2'd0, 64'h00, 2'd0, 1'b0);
        expect_rd("R10", 9'h180, 2'd0, 2'd0, 64'h00, 1'b0);
    endtask

    task automatic t_access;
        expect_rd("R9", 9'h080, 2'd3, 2'd0, 64'h0810_0400_0000_0000, 1'b0);
        expect_rd("R9", 9'h084, 2'd2, 2'd0, 64'h0810_0400, 1'b0);
        expect_rd("R9", 9'h086, 2'd1, 2'd0, 64'h0810, 1'b0);
        expect_rd("R9", 9'h082, 2'd2, 2'd0, 64'd0, 1'b1);
        expect_rd("R9", 9'h008, 2'd0, 2'd0, 64'd0, 1'b1);
        expect_rd("R9", 9'h1F0, 2'd3, 2'd0, 64'd0, 1'b1);
        expect_wr("R9", 9'h021, 2'd1, 64'hFFFF, 2'd0, 1'b1);
        expect_rd("R9", 9'h020, 2'd1, 2'd0, 64'h00E0, 1'b0);
        expect_wr("R9", 9'h038, 2'd3, 64'hA5A5_0000_1234_5A5A, 2'd0, 1'b0);
        expect_rd("R9", 9'h038, 2'd3, 2'd0, 64'hA5A5_0000_1234_5A5A, 1'b0);
    endtask

    task automatic t_stored;
        expect_wr("R11", 9'h010, 2'd1, 64'hBEEF, 2'd0, 1'b0);
        expect_rd("R11", 9'h010, 2'd1, 2'd0, 64'hBEEF, 1'b0);
        expect_wr("R11", 9'h048, 2'd2, 64'h1234_5678, 2'd0, 1'b0);
        expect_rd("R11", 9'h048, 2'd2, 2'd0, 64'h1234_5678, 1'b0);
        check("R11", "stored regs do not route", {48'd0, parent_irq}, 64'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_route();
        t_enable_edge();
        t_w1c();
        t_remap();
        t_withdraw();
        t_encoded();
        t_config();
        t_access();
        t_stored();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule